// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Queue

This block sits between an instruction fetch port and a decode stage. It sends a stream of sequential fetch requests, each one a 4-byte word. Every returned word goes into one slot of an eight-slot queue. A word holds either one 32-bit instruction or two packed 16-bit instructions, and the fetch return marks which kind it is. Decode pulls one instruction per cycle through a valid/ready pair. The queue tells decode whether each instruction is a short (16-bit) one. When the queue is empty, a word that arrives from fetch goes straight to the output in the same cycle.

A taken branch arrives as a redirect with a target address. The redirect clears every queued slot at once. Fetch returns that belong to requests sent before the redirect are counted and thrown away as they arrive. If the branch-target buffer already holds the target word, the redirect carries it. That word is queued during the redirect cycle and issues in the next cycle, and fetching restarts one word past the target. Otherwise the target address is requested in the cycle after the redirect, and the target issues when that word returns. A branch that is not taken does not redirect, so the stream continues without a gap.

Top module: `pfq_top`

## Requirements
- R1: The queue has eight slots. A fetch request goes out only while queued words plus outstanding requests number fewer than eight. From empty, with decode stalled, exactly eight requests go out and then `fetchReq` stays low.
- R2: `issueCompressed` is 1 exactly when the issued instruction comes from a word flagged as a 16-bit pair, and 0 for a full 32-bit word.
- R3: A pair word issues its bits 15:0 first and its bits 31:16 second, each zero-extended to 32 bits. The slot is freed only after both halves have issued. A full word issues unchanged.
- R4: Without a redirect, successive fetch requests step `fetchAddr` by 4, and instructions issue in address order.
- R5: In the redirect cycle `issueValid` is 0. All queued slots are discarded. Responses to requests sent before the redirect never reach the output.
- R6: A redirect with `redirHit`=1 issues the instruction held in `redirWord` in the next cycle, splitting it as a pair if `redirPair`=1. Fetching then resumes at target+4.
- R7: A redirect with `redirHit`=0 drives `fetchReq`=1 with `fetchAddr` equal to the target in the next cycle. The target instruction issues in the same cycle its fetch data returns.
- R8: `issueValid` is 0 whenever the queue is empty and no usable fetch data returns. When the queue is empty and usable data returns, that data issues in the same cycle.
- R9: When fetch data returns every cycle and decode is always ready, instructions issue every cycle with no gap.
- R10: After reset, `issueValid` is 0, and `fetchReq` is 1 with `fetchAddr` equal to the `RESET_ADDR` parameter (default 0).
- R11: While `issueValid`=1 and `decReady`=0, and no redirect occurs, the same instruction stays on the output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | output | 1 | Fetch request for the word at `fetchAddr` |
| fetchAddr | output | AW | Byte address of the requested word |
| rspValid | input | 1 | Fetch data returns this cycle, in request order |
| rspData | input | IW | Returned word |
| rspPair | input | 1 | Returned word holds two 16-bit instructions |
| redirValid | input | 1 | Taken-branch redirect |
| redirAddr | input | AW | Redirect target address |
| redirHit | input | 1 | Target word is supplied with the redirect |
| redirWord | input | IW | Prefetched target word (used when `redirHit`=1) |
| redirPair | input | 1 | Prefetched target word is a 16-bit pair |
| decReady | input | 1 | Decode accepts an instruction this cycle |
| issueValid | output | 1 | An instruction is presented to decode |
| issueInstr | output | IW | Presented instruction, zero-extended when short |
| issueCompressed | output | 1 | Presented instruction is 16 bits |

## Verification
The bench redirects while the queue is full and while fetches are in flight. A design that left stale slots or accepted old-path returns would issue a wrong address in the checked stream, or raise `issueValid` in the quiet cycle after a pre-fetched single-word target. Pair words are mixed with full words, and decode readiness is toggled in irregular patterns. Freeing a pair slot after one half, or swapping the halves, would show up as a skipped or reordered instruction. The bench counts requests under a full stall to catch a throttle that is off by one. It measures the redirect latency on both the hit and the miss path, and counts output gaps during steady streaming, so a missing bypass shows up as a lost cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // Strobes from control to the slot storage and output mux
  typedef struct packed {
    logic wrEn;      // write one slot this cycle
    logic wrRedir;   // write source is the redirect word instead of fetch data
    logic useBypass; // queue empty: present incoming fetch data
    logic halfSel;   // present upper half of a pair word
  } pfqStrobe_t;
endpackage

// File: rtl/pfq_data.sv
module pfq_data
  import pfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int HW   = IW / 2
) (
  input  logic          clk,
  input  pfqStrobe_t    strb,
  input  logic [PW-1:0] wrIdx,
  input  logic [PW-1:0] rdIdx,
  input  logic [IW-1:0] rspData,
  input  logic          rspPair,
  input  logic [IW-1:0] redirWord,
  input  logic          redirPair,
  output logic          srcPair,
  output logic [IW-1:0] issueInstr,
  output logic          issueCompressed
);
  logic [IW-1:0] slotWord [DEPTH];
  logic          slotPair [DEPTH];
  logic [IW-1:0] srcWord;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      slotWord[wrIdx] <= strb.wrRedir ? redirWord : rspData;
      slotPair[wrIdx] <= strb.wrRedir ? redirPair : rspPair;
    end
  end

  always_comb begin
    srcWord = strb.useBypass ? rspData : slotWord[rdIdx];
    srcPair = strb.useBypass ? rspPair : slotPair[rdIdx];
    if (!srcPair)
      issueInstr = srcWord;
    else if (strb.halfSel)
      issueInstr = {{HW{1'b0}}, srcWord[IW-1:HW]};
    else
      issueInstr = {{HW{1'b0}}, srcWord[HW-1:0]};
    issueCompressed = srcPair;
  end
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          IW         = 32,
  parameter int          AW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int STEP = IW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rspValid,
  input  logic          redirValid,
  input  logic [AW-1:0] redirAddr,
  input  logic          redirHit,
  input  logic          decReady,
  input  logic          srcPair,
  output logic          fetchReq,
  output logic [AW-1:0] fetchAddr,
  output logic          issueValid,
  output pfqStrobe_t    strb,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] rdIdx,
  output logic [CW-1:0] qCount,
  output logic [CW-1:0] inFlight
);
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count, inFl, dropCnt;
  logic          headHalf;
  logic [AW-1:0] pc;
  logic [CW:0]   used;
  logic          empty, rspUse, fire, srcDone, push, pop;

  function automatic logic [PW-1:0] ptrInc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty      = (count == '0);
    rspUse     = rspValid && (dropCnt == '0) && !redirValid;
    issueValid = !redirValid && (!empty || rspUse);
    fire       = issueValid && decReady;
    srcDone    = fire && (!srcPair || (!empty && headHalf));
    push       = rspUse && !(empty && srcDone);
    pop        = !empty && srcDone;
    used       = {1'b0, count} + {1'b0, inFl};
    fetchReq   = !redirValid && (used < (CW+1)'(DEPTH));

    strb.wrEn      = redirValid ? redirHit : push;
    strb.wrRedir   = redirValid;
    strb.useBypass = empty;
    strb.halfSel   = !empty && headHalf;
    wrIdx          = redirValid ? '0 : wrPtr;
    rdIdx          = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      inFl     <= '0;
      dropCnt  <= '0;
      headHalf <= 1'b0;
      pc       <= RESET_ADDR;
    end else if (redirValid) begin
      rdPtr    <= '0;
      wrPtr    <= redirHit ? PW'(1) : '0;
      count    <= redirHit ? CW'(1) : '0;
      headHalf <= 1'b0;
      pc       <= redirHit ? redirAddr + AW'(STEP) : redirAddr;
      dropCnt  <= inFl - CW'(rspValid);
      inFl     <= inFl - CW'(rspValid);
    end else begin
      if (push) wrPtr <= ptrInc(wrPtr);
      if (pop)  rdPtr <= ptrInc(rdPtr);
      count <= count + CW'(push) - CW'(pop);
      if (fire) headHalf <= !srcDone;
      if (fetchReq) pc <= pc + AW'(STEP);
      inFl <= inFl + CW'(fetchReq) - CW'(rspValid);
      if (rspValid && dropCnt != '0) dropCnt <= dropCnt - 1'b1;
    end
  end

  assign fetchAddr = pc;
  assign qCount    = count;
  assign inFlight  = inFl;
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          IW         = 32,
  parameter int          AW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  output logic          fetchReq,
  output logic [AW-1:0] fetchAddr,
  input  logic          rspValid,
  input  logic [IW-1:0] rspData,
  input  logic          rspPair,
  input  logic          redirValid,
  input  logic [AW-1:0] redirAddr,
  input  logic          redirHit,
  input  logic [IW-1:0] redirWord,
  input  logic          redirPair,
  input  logic          decReady,
  output logic          issueValid,
  output logic [IW-1:0] issueInstr,
  output logic          issueCompressed
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pfqStrobe_t    strb;
  logic [PW-1:0] wrIdx, rdIdx;
  logic          srcPair;
  logic [CW-1:0] qCount, inFlight;

  pfq_ctrl #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .redirValid(redirValid),
    .redirAddr(redirAddr), .redirHit(redirHit), .decReady(decReady),
    .srcPair(srcPair), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .issueValid(issueValid), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .qCount(qCount), .inFlight(inFlight)
  );

  pfq_data #(.DEPTH(DEPTH), .IW(IW)) u_data (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .rspData(rspData), .rspPair(rspPair), .redirWord(redirWord),
    .redirPair(redirPair), .srcPair(srcPair), .issueInstr(issueInstr),
    .issueCompressed(issueCompressed)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HW   = IW / 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          fetchReq,
  input logic [AW-1:0] fetchAddr,
  input logic          rspValid,
  input logic          redirValid,
  input logic [AW-1:0] redirAddr,
  input logic          redirHit,
  input logic [IW-1:0] redirWord,
  input logic          redirPair,
  input logic          decReady,
  input logic          issueValid,
  input logic [IW-1:0] issueInstr,
  input logic [CW-1:0] qCount,
  input logic [CW-1:0] inFlight
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(qCount) + int'(inFlight)) <= DEPTH); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> fetchAddr == $past(fetchAddr) + AW'(IW / 8)); // R4

  AST_REDIR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> !issueValid); // R5

  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && redirHit) |=> redirValid || (issueValid && issueInstr ==
      ($past(redirPair) ? {{HW{1'b0}}, $past(redirWord[HW-1:0])} : $past(redirWord)))); // R6

  AST_MISS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !redirHit) |=> redirValid || fetchAddr == $past(redirAddr)); // R7

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == '0 && !rspValid) |-> !issueValid); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !decReady) |=> redirValid || (issueValid && $stable(issueInstr))); // R11
endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) u_pfqChk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .rspValid(rspValid), .redirValid(redirValid), .redirAddr(redirAddr),
  .redirHit(redirHit), .redirWord(redirWord), .redirPair(redirPair),
  .decReady(decReady), .issueValid(issueValid), .issueInstr(issueInstr),
  .qCount(qCount), .inFlight(inFlight)
);

// File: tb/pfq_top_bench.sv
`timescale 1ns/100ps
module pfq_top_bench;
  localparam int DEPTH = 8;
  localparam int IW    = 32;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          fetchReq;
  logic [AW-1:0] fetchAddr;
  logic          rspValid;
  logic [IW-1:0] rspData;
  logic          rspPair;
  logic          redirValid = 1'b0;
  logic [AW-1:0] redirAddr = '0;
  logic          redirHit = 1'b0;
  logic [IW-1:0] redirWord = '0;
  logic          redirPair = 1'b0;
  logic          decReady = 1'b0;
  logic          issueValid;
  logic [IW-1:0] issueInstr;
  logic          issueCompressed;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  pfq_top #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .RESET_ADDR('0)) u_pfq_top (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .rspValid(rspValid), .rspData(rspData), .rspPair(rspPair),
    .redirValid(redirValid), .redirAddr(redirAddr), .redirHit(redirHit),
    .redirWord(redirWord), .redirPair(redirPair), .decReady(decReady),
    .issueValid(issueValid), .issueInstr(issueInstr),
    .issueCompressed(issueCompressed)
  );

  // Memory image: word content from address; bit 4 of the address marks a pair
  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h0101};
  endfunction
  function automatic logic memPair(input logic [31:0] a);
    return a[4];
  endfunction
  function automatic logic [31:0] expInstr(input logic [31:0] a, input bit upper);
    logic [31:0] w = memWord(a);
    if (!memPair(a)) return w;
    return upper ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  // Fetch port model: in-order, two-cycle return
  logic          pV0, pV1;
  logic [AW-1:0] pA0, pA1;
  always @(posedge clk) begin
    if (!rstN) begin
      pV0 <= 1'b0; pV1 <= 1'b0; pA0 <= '0; pA1 <= '0;
    end else begin
      pV0 <= fetchReq; pA0 <= fetchAddr;
      pV1 <= pV0;      pA1 <= pA0;
    end
  end
  assign rspValid = pV1;
  assign rspData  = memWord(pA1);
  assign rspPair  = memPair(pA1);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nFail++;
      $display("FAIL watchdog all-requirements act=%0d exp<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  // {target, hit, decode-ready mask}
  localparam logic [40:0] VECS [6] = '{
    {32'h0000_1000, 1'b0, 8'hFF},
    {32'h0000_2010, 1'b1, 8'hFF},
    {32'h0000_3008, 1'b0, 8'hB5},
    {32'h0000_4000, 1'b1, 8'hAA},
    {32'h0000_5014, 1'b0, 8'hFF},
    {32'h0000_600C, 1'b1, 8'h0F}
  };

  task automatic runVector(input logic [31:0] t, input bit hit, input logic [7:0] mask);
    logic [31:0] ea;
    bit eh, started;
    int got, bubbles;
    @(negedge clk);
    redirValid = 1'b1; redirAddr = t; redirHit = hit;
    redirWord = memWord(t); redirPair = memPair(t);
    #1;
    chk(!issueValid, "R5 silent redirect cycle", 32'(issueValid), 0);
    @(negedge clk);
    redirValid = 1'b0;
    ea = t; eh = 0; got = 0; bubbles = 0; started = 0;
    for (int cyc = 1; cyc < 80 && got < 12; cyc++) begin
      decReady = mask[cyc % 8];
      #1;
      if (cyc == 1) begin
        if (hit) begin
          chk(issueValid && issueInstr == expInstr(t, 0), "R6 hit target next cycle", issueInstr, expInstr(t, 0));
          chk(fetchAddr == t + 4, "R6 fetch resumes at target+4", fetchAddr, t + 4);
        end else begin
          chk(fetchReq && fetchAddr == t, "R7 miss fetches target", fetchAddr, t);
        end
      end
      if (issueValid && !started) begin
        started = 1;
        if (!hit) chk(cyc == 3, "R7 miss target issues on return", cyc, 3);
      end else if (!issueValid && started) begin
        bubbles++;
      end
      if (issueValid && decReady) begin
        chk(issueInstr == expInstr(ea, eh), "R3 instruction order and halves", issueInstr, expInstr(ea, eh));
        chk(issueCompressed == memPair(ea), "R2 short flag", 32'(issueCompressed), 32'(memPair(ea)));
        if (memPair(ea) && !eh) eh = 1;
        else begin ea = ea + 4; eh = 0; end
        got++;
      end
      @(negedge clk);
    end
    chk(got == 12, "R4 sequential stream delivered", got, 12);
    if (mask == 8'hFF && !hit) chk(bubbles == 0, "R9 no gaps in steady stream", bubbles, 0);
  endtask

  initial begin
    int reqs;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    decReady = 1'b0;
    #1;
    chk(!issueValid, "R10 reset output idle", 32'(issueValid), 0);
    chk(fetchReq && fetchAddr == 32'h0, "R10 reset fetch address", fetchAddr, 0);

    // Full stall from empty: throttle and hold
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      if (fetchReq) reqs++;
      @(negedge clk);
      #1;
    end
    chk(reqs == DEPTH, "R1 requests until full", reqs, DEPTH);
    chk(!fetchReq, "R1 fetch stopped when full", 32'(fetchReq), 0);
    chk(issueValid && issueInstr == expInstr(0, 0), "R11 output held during stall", issueInstr, expInstr(0, 0));
    @(negedge clk);
    #1;
    chk(issueValid && issueInstr == expInstr(0, 0), "R11 output still held", issueInstr, expInstr(0, 0));

    // Vector table: redirect from whatever state the previous run left
    foreach (VECS[k]) runVector(VECS[k][40:9], VECS[k][8], VECS[k][7:0]);

    // Hit to a single word while old-path fetches are in flight
    runVector(32'h0000_8000, 1'b0, 8'hFF);
    redirValid = 1'b1; redirAddr = 32'h0000_7000; redirHit = 1'b1;
    redirWord = memWord(32'h0000_7000); redirPair = 1'b0; decReady = 1'b1;
    #1;
    chk(!issueValid, "R5 silent redirect cycle", 32'(issueValid), 0);
    @(negedge clk);
    redirValid = 1'b0;
    #1;
    chk(issueValid && issueInstr == memWord(32'h0000_7000), "R6 single hit target", issueInstr, memWord(32'h0000_7000));
    @(negedge clk);
    #1;
    chk(!issueValid, "R8 empty with only stale returns", 32'(issueValid), 0);
    @(negedge clk);
    #1;
    chk(issueValid && issueInstr == memWord(32'h0000_7004), "R8 bypass of returning word", issueInstr, memWord(32'h0000_7004));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule